// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries data words from a write clock domain to an unrelated read clock domain through a dual-port storage array. Each side keeps its own binary pointer. Each pointer is also kept as a Gray-coded copy, and that copy is resynchronized through two flip-flops into the opposite clock. Every status flag is computed and registered in the clock of the port that uses it. Write-side flags therefore need no further crossing, and neither do read-side flags.

Two things are sampled while reset is held: the flag style and the threshold source. The standard style reports full and empty. The fall-through style reports write-ready and read-valid, and it presents the oldest word on the read outputs before any read request arrives. The almost-empty and almost-full thresholds use one of three fixed offsets. The alternative is a pair of offsets that the first two writes after reset supply through the write data port.

Top module: `xclk_fifo`

## Requirements
- R1: Every accepted word leaves the read port exactly once and in write order, in both flag styles. Each pointer advances by at most one per clock of its own domain.
- R2: In standard style (`fwft_mode`=0), a read accepted at a read clock edge places its word on `rd_data` at that same edge. Once both domains have settled, `wr_flag`=1 exactly when DEPTH words are stored, and `rd_flag`=1 exactly when none are stored.
- R3: In fall-through style (`fwft_mode`=1), `rd_flag`=1 means `rd_data` already holds the oldest unread word, with no read request needed. That word and `rd_flag` hold until a read is requested. An output register adds one word to the capacity, for DEPTH+1 in total. `wr_flag`=1 (ready) while the array holds fewer than DEPTH words.
- R4: `fwft_mode` and `thr_sel` are sampled only while `rst_n` is low. Changing them after reset has no effect.
- R5: Once settled, `almost_empty`=1 exactly when the count of unread words is at or below the almost-empty offset. In fall-through style, this count includes the word in the output register.
- R6: Once settled, `almost_full`=1 exactly when the array word count exceeds DEPTH minus the almost-full offset. In fall-through style, this count excludes the output register.
- R7: `thr_sel` codes 0, 1 and 2 select a common offset of 8, 16 and 64 for both thresholds.
- R8: With `thr_sel`=3, the first two writes after reset load the almost-empty offset and then the almost-full offset, each from `wr_data[AW:0]`. These two words are not stored. Until both have been written, `wr_flag` shows not-ready: 1 in standard style, 0 in fall-through style.
- R9: A write while the FIFO is full or not ready is ignored. A read while it is empty (standard) or while `rd_flag`=0 (fall-through) is ignored. Neither changes any pointer, flag or stored word.
- R10: After reset, `rd_flag` is 1 in standard style and 0 in fall-through style, `almost_empty`=1 and `almost_full`=0. `wr_flag` is 0 in standard style and 1 in fall-through style, except in the case R8 describes.
- R11: The Gray copy of each pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| rclk | input | 1 | Read port clock, unrelated to wclk |
| rst_n | input | 1 | Active-low reset, synchronous in each domain |
| fwft_mode | input | 1 | Flag style sampled in reset: 0 standard, 1 fall-through |
| thr_sel | input | 2 | Threshold source sampled in reset: 0/1/2 fixed 8/16/64, 3 loaded |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data, or an offset word while loading |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data |
| wr_flag | output | 1 | Full (standard) or write-ready (fall-through) |
| rd_flag | output | 1 | Empty (standard) or read-valid (fall-through) |
| almost_full | output | 1 | Array count above DEPTH minus the almost-full offset |
| almost_empty | output | 1 | Unread count at or below the almost-empty offset |

## Verification
The bench builds the block with a data width of 36 and AW=7, which gives a depth of 128. With that depth, every fixed offset including 64 falls inside the array, and a complete fill and drain stays short. The bench steps the fill level one word at a time and checks all four flags against a reference count at each level, in both styles, for every fixed offset and for loaded offsets. Random traffic runs on a 200 MHz write clock and a 137 MHz read clock so that the pointer crossings are exercised at every phase relation between the two clocks.

// File: rtl/xf_pkg.sv
// Shared definitions for the dual-clock FIFO: threshold-select codes,
// the fixed offset table and Gray-to-binary conversion.
package xf_pkg;

    typedef enum logic [1:0] {
        THR_8    = 2'd0,
        THR_16   = 2'd1,
        THR_64   = 2'd2,
        THR_PROG = 2'd3
    } thr_sel_e;

    // Fixed offset for a select code; the loaded code returns zero.
    function automatic logic [31:0] fixed_offset(input logic [1:0] sel);
        case (sel)
            THR_8:   fixed_offset = 32'd8;
            THR_16:  fixed_offset = 32'd16;
            THR_64:  fixed_offset = 32'd64;
            default: fixed_offset = 32'd0;
        endcase
    endfunction

    // Gray to binary for any width up to 32; the caller zero-extends and truncates.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        gray_to_bin = b;
    endfunction

endpackage

// File: rtl/xf_sync.sv
// Two-flop resynchronizer for a bus into the destination clock.
// Assumes the input is a registered value that changes at most one bit
// per source clock (Gray code) or is quasi-static.
module xf_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    // Two register stages in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/xf_ram.sv
// Storage array: one write port on wclk, an asynchronous read port.
// The read side registers the data it takes, so no read clock is needed here.
module xf_ram #(
    parameter int DW = 36,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array write on accepted writes.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xf_wr_side.sv
// Write-domain control: captures the mode and threshold source during reset,
// loads the two offset words when they are chosen, accepts writes, keeps the
// binary and Gray write pointers, and registers the full/ready and almost-full
// flags. The read pointer arrives already synchronized as Gray code.
// Assumes AW >= 6, so that a fixed offset of 64 fits in a pointer-wide field.
module xf_wr_side
    import xf_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        fwft_mode,
    input  logic [1:0]  thr_sel,
    input  logic        wr_en,
    input  logic [AW:0] cfg_word,
    input  logic [AW:0] rgray_s,
    output logic        mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        cfg_done,
    output logic [AW:0] ae_off,
    output logic        wr_flag,
    output logic        almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          fwft_q;
    logic [1:0]    sel_q;
    logic [1:0]    ld_cnt;
    logic [PW-1:0] ae_off_q, af_off_q;
    logic          full_q, af_q;

    logic          prog, accept, load;
    logic [PW-1:0] af_eff, wbin_n, wgray_n, rbin_s, wcount_n, full_pat;
    logic [PW:0]   af_lim;

    assign prog     = (sel_q == THR_PROG);
    assign cfg_done = !prog || ld_cnt[1];
    assign accept   = wr_en && cfg_done && !full_q;
    assign load     = wr_en && !cfg_done;

    assign af_eff = prog ? af_off_q : PW'(fixed_offset(sel_q));
    assign ae_off = prog ? ae_off_q : PW'(fixed_offset(sel_q));

    // Next-state pointer, occupancy and flag terms.
    always_comb begin
        wbin_n   = wbin + {{(PW-1){1'b0}}, accept};
        wgray_n  = wbin_n ^ (wbin_n >> 1);
        rbin_s   = PW'(gray_to_bin(32'(rgray_s)));
        wcount_n = wbin_n - rbin_s;
        full_pat = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
        af_lim   = {1'b0, PW'(DEPTH)} - {1'b0, af_eff};
    end

    // Mode capture during reset, offset loading, pointers and flags.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            fwft_q   <= fwft_mode;
            sel_q    <= thr_sel;
            ld_cnt   <= 2'd0;
            ae_off_q <= '0;
            af_off_q <= '0;
            wbin     <= '0;
            wgray    <= '0;
            full_q   <= 1'b0;
            af_q     <= 1'b0;
        end else begin
            if (load) begin
                if (ld_cnt == 2'd0) ae_off_q <= cfg_word;
                else                af_off_q <= cfg_word;
                ld_cnt <= ld_cnt + 2'd1;
            end
            wbin   <= wbin_n;
            wgray  <= wgray_n;
            full_q <= (wgray_n == full_pat);
            af_q   <= ({1'b0, wcount_n} > af_lim);
        end
    end

    assign mem_we      = accept;
    assign mem_waddr   = wbin[AW-1:0];
    assign wr_flag     = fwft_q ? (cfg_done && !full_q) : (full_q || !cfg_done);
    assign almost_full = af_q;
endmodule

// File: rtl/xf_rd_side.sv
// Read-domain control: captures the mode and threshold source during reset,
// accepts reads in standard style or refills the output register in
// fall-through style, keeps the binary and Gray read pointers, and registers
// the empty/valid and almost-empty flags. The write pointer arrives already
// synchronized as Gray code; the loaded almost-empty offset is quasi-static
// and is copied once the synchronized load-done bit is seen.
module xf_rd_side
    import xf_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 9
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic [1:0]    thr_sel,
    input  logic          rd_en,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW:0]   wgray_s,
    input  logic          cfg_done_s,
    input  logic [AW:0]   ae_off_w,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic          fwft_q;
    logic [1:0]    sel_q;
    logic [PW-1:0] ae_q;
    logic          empty_q, vld_q, aem_q;
    logic [DW-1:0] dout_q;

    logic          prog, mem_empty, take, vld_n;
    logic [PW-1:0] ae_eff, rbin_n, rgray_n, wbin_s, rcount_n;

    assign prog      = (sel_q == THR_PROG);
    assign ae_eff    = prog ? ae_q : PW'(fixed_offset(sel_q));
    assign mem_empty = (rgray == wgray_s);

    // Read acceptance and next-state pointer, valid and occupancy.
    always_comb begin
        if (fwft_q) take = !mem_empty && (!vld_q || rd_en);
        else        take = rd_en && !empty_q;
        if (!fwft_q)    vld_n = 1'b0;
        else if (take)  vld_n = 1'b1;
        else if (rd_en) vld_n = 1'b0;
        else            vld_n = vld_q;
        rbin_n   = rbin + {{(PW-1){1'b0}}, take};
        rgray_n  = rbin_n ^ (rbin_n >> 1);
        wbin_s   = PW'(gray_to_bin(32'(wgray_s)));
        rcount_n = wbin_s - rbin_n + {{(PW-1){1'b0}}, vld_n};
    end

    // Mode capture during reset, offset copy, pointers, output data and flags.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            fwft_q  <= fwft_mode;
            sel_q   <= thr_sel;
            ae_q    <= '0;
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
            vld_q   <= 1'b0;
            aem_q   <= 1'b1;
            dout_q  <= '0;
        end else begin
            if (prog && cfg_done_s) ae_q <= ae_off_w;
            if (take) dout_q <= mem_rdata;
            rbin    <= rbin_n;
            rgray   <= rgray_n;
            empty_q <= (rgray_n == wgray_s);
            vld_q   <= vld_n;
            aem_q   <= (rcount_n <= ae_eff);
        end
    end

    assign mem_raddr    = rbin[AW-1:0];
    assign rd_data      = dout_q;
    assign rd_flag      = fwft_q ? vld_q : empty_q;
    assign almost_empty = aem_q;
endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO top: joins the storage array, the write-side and read-side
// controls and the pointer resynchronizers. The reset is one active-low
// input, applied synchronously in each domain; it must be held for several
// cycles of the slower clock.
module xclk_fifo #(
    parameter int DW = 36,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic [1:0]    thr_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          wr_flag,
    output logic          rd_flag,
    output logic          almost_full,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] rg_sync_w, wg_sync_r, ae_off_w;
    logic          cfg_done_w, cfg_done_r;

    xf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    xf_wr_side #(.AW(AW)) u_wr (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .fwft_mode   (fwft_mode),
        .thr_sel     (thr_sel),
        .wr_en       (wr_en),
        .cfg_word    (wr_data[PW-1:0]),
        .rgray_s     (rg_sync_w),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .wbin        (w_bin),
        .wgray       (w_gray),
        .cfg_done    (cfg_done_w),
        .ae_off      (ae_off_w),
        .wr_flag     (wr_flag),
        .almost_full (almost_full)
    );

    xf_sync #(.W(PW)) u_sync_r2w (
        .clk (wclk), .rst_n (rst_n), .din (r_gray), .dout (rg_sync_w)
    );

    xf_sync #(.W(PW)) u_sync_w2r (
        .clk (rclk), .rst_n (rst_n), .din (w_gray), .dout (wg_sync_r)
    );

    xf_sync #(.W(1)) u_sync_cfg (
        .clk (rclk), .rst_n (rst_n), .din (cfg_done_w), .dout (cfg_done_r)
    );

    xf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .thr_sel      (thr_sel),
        .rd_en        (rd_en),
        .mem_rdata    (mem_rdata),
        .wgray_s      (wg_sync_r),
        .cfg_done_s   (cfg_done_r),
        .ae_off_w     (ae_off_w),
        .mem_raddr    (mem_raddr),
        .rbin         (r_bin),
        .rgray        (r_gray),
        .rd_data      (rd_data),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );
endmodule

// File: rtl/xf_chk.sv
// Property checker for xclk_fifo, attached by bind. It captures the mode
// inputs during reset in each domain, as the design does, and checks pointer
// behaviour and flag protocol.
module xf_chk #(
    parameter int DW = 36,
    parameter int AW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          fwft_mode,
    input logic [1:0]    thr_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_flag,
    input logic          rd_flag,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   r_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_gray
);
    logic       fwft_w, fwft_r, prog_w;
    logic [1:0] ld_w;

    // Write-domain mode capture and offset-word count.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            fwft_w <= fwft_mode;
            prog_w <= (thr_sel == 2'd3);
            ld_w   <= 2'd0;
        end else if (prog_w && wr_en && ld_w != 2'd2) begin
            ld_w <= ld_w + 2'd1;
        end
    end

    // Read-domain mode capture.
    always_ff @(posedge rclk) begin
        if (!rst_n) fwft_r <= fwft_mode;
    end

    // R9
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && (fwft_w ? !wr_flag : wr_flag)) |=> $stable(w_bin));

    // R9
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_r && rd_en && rd_flag) |=> $stable(r_bin));

    // R3
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_r && rd_flag && !rd_en) |=> (rd_flag && $stable(rd_data)));

    // R8
    cfg_gate_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (prog_w && ld_w != 2'd2) |-> (wr_flag == !fwft_w));

    // R1
    wptr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> (w_bin == $past(w_bin) || w_bin == $past(w_bin) + 1'b1));

    // R1
    rptr_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> (r_bin == $past(r_bin) || r_bin == $past(r_bin) + 1'b1));

    // R11
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> $onehot0(w_gray ^ $past(w_gray)));

    // R11
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> $onehot0(r_gray ^ $past(r_gray)));
endmodule

bind xclk_fifo xf_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst_n     (rst_n),
    .fwft_mode (fwft_mode),
    .thr_sel   (thr_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_flag   (wr_flag),
    .rd_flag   (rd_flag),
    .rd_data   (rd_data),
    .w_bin     (w_bin),
    .r_bin     (r_bin),
    .w_gray    (w_gray),
    .r_gray    (r_gray)
);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed fill/drain level sweeps with flag checks,
// plus seeded random traffic on unrelated clocks against a scoreboard queue.
module xclk_fifo_test;
    localparam int DW    = 36;
    localparam int AW    = 7;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          fwft_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]    thr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_flag, rd_flag, almost_full, almost_empty;

    int nchk = 0, nerr = 0;
    logic [DW-1:0] sb[$];
    bit   cur_fwft;
    int   aeo, afo;
    bit   wdone;

    xclk_fifo #(.DW(DW), .AW(AW)) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
        .thr_sel(thr_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .wr_flag(wr_flag), .rd_flag(rd_flag),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    always #2.5  wclk = ~wclk;
    always #3.65 rclk = ~rclk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom(), $urandom()} & {DW{1'b1}};
    endfunction

    function automatic bit has_room();
        return cur_fwft ? wr_flag : !wr_flag;
    endfunction

    task automatic settle();
        repeat (8) @(negedge rclk);
        @(negedge wclk);
    endtask

    // Expected flags from the reference count (R2, R3, R5, R6).
    task automatic check_flags(input int cnt, input string tag);
        int  memc;
        bit  e_wr, e_rd, e_ae, e_af;
        memc = cur_fwft ? ((cnt > 0) ? cnt - 1 : 0) : cnt;
        e_wr = cur_fwft ? (memc < DEPTH) : (memc == DEPTH);
        e_rd = cur_fwft ? (cnt > 0) : (cnt == 0);
        e_ae = (cnt <= aeo);
        e_af = (memc > DEPTH - afo);
        check(wr_flag == e_wr, {tag, " R2/R3 wr_flag"}, 64'(wr_flag), 64'(e_wr));
        check(rd_flag == e_rd, {tag, " R2/R3 rd_flag"}, 64'(rd_flag), 64'(e_rd));
        check(almost_empty == e_ae, {tag, " R5 almost_empty"}, 64'(almost_empty), 64'(e_ae));
        check(almost_full == e_af, {tag, " R6 almost_full"}, 64'(almost_full), 64'(e_af));
    endtask

    task automatic write_one(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    // One read with data check against the scoreboard (R1, R2, R3).
    task automatic read_one();
        logic [DW-1:0] e;
        @(negedge rclk);
        if (cur_fwft) begin
            if (rd_flag) begin
                e = sb.pop_front();
                check(rd_data == e, "R1/R3 fall-through data", 64'(rd_data), 64'(e));
                rd_en = 1'b1;
            end
            @(negedge rclk);
            rd_en = 1'b0;
        end else begin
            if (!rd_flag) begin
                e = sb.pop_front();
                rd_en = 1'b1;
                @(negedge rclk);
                rd_en = 1'b0;
                check(rd_data == e, "R1/R2 standard data", 64'(rd_data), 64'(e));
            end
        end
    endtask

    task automatic do_reset(input bit fw, input logic [1:0] sel);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        fwft_mode = fw; thr_sel = sel;
        cur_fwft = fw;
        aeo = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : (sel == 2'd2) ? 64 : 0;
        afo = aeo;
        sb.delete();
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        // R4: mode inputs change after reset and must be ignored.
        fwft_mode = ~fw; thr_sel = ~sel;
        @(negedge rclk);
        // R10
        check(rd_flag == !fw, "R10 reset rd_flag", 64'(rd_flag), 64'(!fw));
        check(almost_empty == 1'b1, "R10 reset almost_empty", 64'(almost_empty), 64'd1);
        check(almost_full == 1'b0, "R10 reset almost_full", 64'(almost_full), 64'd0);
        if (sel != 2'd3)
            check(wr_flag == fw, "R10 reset wr_flag", 64'(wr_flag), 64'(fw));
        else
            check(wr_flag == !fw, "R8 reset wr_flag not ready", 64'(wr_flag), 64'(!fw));
    endtask

    task automatic load_offsets(input int ae, input int af);
        write_one(DW'(ae));
        settle();
        check(wr_flag == !cur_fwft, "R8 not ready after one offset word", 64'(wr_flag), 64'(!cur_fwft));
        write_one(DW'(af));
        aeo = ae; afo = af;
        settle();
        check(wr_flag == cur_fwft, "R8 ready after both offset words", 64'(wr_flag), 64'(cur_fwft));
        check_flags(0, "R8 offset words not stored");
    endtask

    task automatic directed_sweep();
        logic [DW-1:0] w;
        // Fill level by level (R4 mode as sampled, R7 offsets).
        while (has_room()) begin
            w = rnd_word();
            sb.push_back(w);
            write_one(w);
            settle();
            check_flags(sb.size(), "R4/R7 fill");
        end
        check(sb.size() == (cur_fwft ? DEPTH + 1 : DEPTH), "R2/R3 capacity",
              64'(sb.size()), 64'(cur_fwft ? DEPTH + 1 : DEPTH));
        // R9: writes while full are ignored.
        repeat (3) write_one(rnd_word());
        settle();
        check_flags(sb.size(), "R9 after writes while full");
        while (sb.size() > 0) begin
            read_one();
            settle();
            check_flags(sb.size(), "R7 drain");
        end
        // R9: reads while empty are ignored.
        repeat (3) begin
            @(negedge rclk); rd_en = 1'b1;
            @(negedge rclk); rd_en = 1'b0;
        end
        settle();
        check_flags(0, "R9 after reads while empty");
        w = rnd_word();
        sb.push_back(w);
        write_one(w);
        settle();
        if (cur_fwft) begin
            check(rd_flag == 1'b1, "R3 first word valid without read", 64'(rd_flag), 64'd1);
            check(rd_data == w, "R3 first word on outputs", 64'(rd_data), 64'(w));
        end
        read_one();
        settle();
        check_flags(0, "R9 pointers intact");
    endtask

    task automatic random_traffic(input int ncyc);
        wdone = 1'b0;
        fork
            begin : writer
                for (int i = 0; i < ncyc; i++) begin
                    logic [DW-1:0] w;
                    @(negedge wclk);
                    wr_en = 1'b0;
                    if (has_room() && ($urandom() % 3 != 0)) begin
                        w = rnd_word();
                        wr_en = 1'b1; wr_data = w;
                        sb.push_back(w);
                    end
                end
                @(negedge wclk);
                wr_en = 1'b0;
                wdone = 1'b1;
            end
            begin : reader
                bit pend = 1'b0;
                logic [DW-1:0] e = '0;
                while (!(wdone && sb.size() == 0 && !pend)) begin
                    @(negedge rclk);
                    if (cur_fwft) begin
                        rd_en = 1'b0;
                        if (rd_flag && ($urandom() % 4 != 0)) begin
                            e = sb.pop_front();
                            check(rd_data == e, "R1 random fall-through data", 64'(rd_data), 64'(e));
                            rd_en = 1'b1;
                        end
                    end else begin
                        if (pend) begin
                            check(rd_data == e, "R1 random standard data", 64'(rd_data), 64'(e));
                            pend = 1'b0;
                        end
                        rd_en = 1'b0;
                        if (!rd_flag && ($urandom() % 4 != 0)) begin
                            e = sb.pop_front();
                            rd_en = 1'b1;
                            pend = 1'b1;
                        end
                    end
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
        settle();
        check_flags(0, "R1 after random traffic");
    endtask

    task automatic run_cfg(input bit fw, input logic [1:0] sel, input int ae, input int af);
        do_reset(fw, sel);
        if (sel == 2'd3) load_offsets(ae, af);
        directed_sweep();
        random_traffic(2500);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_cfg(1'b0, 2'd0, 0, 0);
        run_cfg(1'b0, 2'd3, 5, 10);
        run_cfg(1'b1, 2'd1, 0, 0);
        run_cfg(1'b1, 2'd2, 0, 0);
        run_cfg(1'b1, 2'd3, 3, 100);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(150000 * 5);
        nerr++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule